// File: doc/BRIEF.md
# Streaming Block ECC Generator

This block listens to a byte stream as it passes along a data path and builds a 24-bit Hamming-style error-correction code over one 512-byte block. A write strobe from the register bank restarts the calculation. From that strobe onward, every byte qualified by `byte_valid` is folded into the code. The byte's position in the block is taken from a 10-bit counter.

When the 512th byte has been absorbed, the block raises `block_done`. It then holds the code and the count frozen, whatever traffic follows, until the next restart strobe. After power-up the block stays idle with a cleared result, and it counts nothing until software issues the first restart.

The control is a three-state machine:

- `ST_IDLE`: power-up state; bytes are ignored.
- `ST_ACCUM`: bytes are counted and folded into the code.
- `ST_DONE`: the result is frozen.

The transitions are:

- `restart` (any state to `ST_ACCUM`).
- `block_end` (`ST_ACCUM` to `ST_DONE`, taken on the accepted byte whose index is 511).
- `hold` (each state back to itself).

Top module: `ecc_block_gen`

## Requirements
- R1: After reset, `block_done`=0, `byte_count`=0 and `ecc_result`=0. Until the first `restart_wr` pulse, valid bytes change none of them.
- R2: A one-cycle `restart_wr` pulse, in any state, clears `ecc_result`, `byte_count` and `block_done`. The cleared values are visible in the cycle after the pulse.
- R3: After a restart, each clock edge with `byte_valid`=1 increments `byte_count` by one. An edge with `byte_valid`=0 leaves all outputs unchanged.
- R4: Line parity is defined as follows.
  - The k-th accepted byte has index a = k-1 (9 bits), and p is the XOR of the byte's 8 bits.
  - For each address bit n in 0..8, `ecc_result[2n]` is the XOR of p over bytes with a[n]=0.
  - `ecc_result[2n+1]` is the XOR of p over bytes with a[n]=1.
- R5: Column parity is defined as follows.
  - Let X be the bitwise XOR of all accepted bytes.
  - For j in 0..2, `ecc_result[18+2j]` is the XOR of the bits X[i] whose position i has bit j clear.
  - `ecc_result[19+2j]` is the XOR of the bits X[i] whose position i has bit j set.
- R6: The edge that accepts the 512th byte sets `block_done`=1 and `byte_count`=512. The final code is visible from that same edge.
- R7: While `block_done`=1, further valid bytes change neither `ecc_result` nor `byte_count`. `byte_count` never exceeds 512.
- R8: When `restart_wr` and `byte_valid` are high in the same cycle, the restart wins and that byte is not counted.
- R9: A restart part way through a block discards the partial code. The next block's code depends only on bytes accepted after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart_wr | input | 1 | Register-write strobe that restarts the calculation |
| byte_valid | input | 1 | Qualifies `byte_data` in this cycle |
| byte_data | input | 8 | Byte tapped from the data path |
| ecc_result | output | 24 | Code: line parity in bits 17:0, column parity in bits 23:18 |
| block_done | output | 1 | High once the block is complete, until the next restart |
| byte_count | output | 10 | Bytes accepted since the last restart, saturating at 512 |

## Verification
A wrong state or count in the control shows up at the ports on the very next edge. Examples are a byte counted while idle, a count that runs past 512, or a code that keeps moving after completion. `byte_count` and `block_done` expose the machine directly.

A wrong address bit or parity polarity inside the accumulators stays hidden until the block finishes. It then appears as specific bit pairs of `ecc_result` differing from the arithmetic model. Single-byte blocks placed at chosen addresses isolate each pair.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } ecc_state_t;
endpackage

// File: rtl/ecc_ctrl_fsm.sv
module ecc_ctrl_fsm
    import ecc_gen_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    localparam int ADDR_W = $clog2(BLOCK_BYTES),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              byte_valid,
    output logic              clr,
    output logic              acc_en,
    output logic              done,
    output logic              armed,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLOCK_BYTES);

    ecc_state_t state_q, state_d;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: restart, block_end, hold
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ACCUM: if (byte_valid && count_q == LAST_IDX) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        clr    = restart;
        acc_en = 1'b0;
        done   = 1'b0;
        armed  = 1'b1;
        unique case (state_q)
            ST_IDLE:  armed  = 1'b0;
            ST_ACCUM: acc_en = byte_valid && !restart;
            ST_DONE:  done   = 1'b1;
            default:  armed  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (clr)    count_q <= '0;
        else if (acc_en) count_q <= count_q + 1'b1;
    end

    assign count = count_q;
    assign addr  = count_q[ADDR_W-1:0];

    assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);
    assert_done_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> count_q == FULL_CNT);
    assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count_q == '0) && !done);
    assert_idle_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !restart) |=> count_q == '0);
endmodule

// File: rtl/ecc_line_parity.sv
module ecc_line_parity #(
    parameter int ADDR_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                par_bit,
    output logic [2*ADDR_W-1:0] lp
);
    for (genvar n = 0; n < ADDR_W; n++) begin : g_bit
        logic even_q, odd_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                even_q <= 1'b0;
                odd_q  <= 1'b0;
            end else if (clr) begin
                even_q <= 1'b0;
                odd_q  <= 1'b0;
            end else if (en) begin
                if (addr[n]) odd_q  <= odd_q ^ par_bit;
                else         even_q <= even_q ^ par_bit;
            end
        end
        assign lp[2*n]   = even_q;
        assign lp[2*n+1] = odd_q;
    end
endmodule

// File: rtl/ecc_col_parity.sv
module ecc_col_parity #(
    parameter int DATA_W = 8,
    localparam int COL_BITS = $clog2(DATA_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    input  logic [DATA_W-1:0]     data,
    output logic [2*COL_BITS-1:0] cp
);
    logic [DATA_W-1:0] xacc_q;

    function automatic logic [DATA_W-1:0] pos_mask(input int j, input logic odd);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (((i >> j) & 1) == 1) == odd;
        return m;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   xacc_q <= '0;
        else if (clr) xacc_q <= '0;
        else if (en)  xacc_q <= xacc_q ^ data;
    end

    for (genvar j = 0; j < COL_BITS; j++) begin : g_col
        assign cp[2*j]   = ^(xacc_q & pos_mask(j, 1'b0));
        assign cp[2*j+1] = ^(xacc_q & pos_mask(j, 1'b1));
    end
endmodule

// File: rtl/ecc_block_gen.sv
module ecc_block_gen #(
    parameter int BLOCK_BYTES = 512,
    parameter int DATA_W      = 8,
    localparam int ADDR_W   = $clog2(BLOCK_BYTES),
    localparam int CNT_W    = ADDR_W + 1,
    localparam int COL_BITS = $clog2(DATA_W),
    localparam int ECC_W    = 2*ADDR_W + 2*COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_wr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    output logic [ECC_W-1:0]  ecc_result,
    output logic              block_done,
    output logic [CNT_W-1:0]  byte_count
);
    logic              clr, acc_en, armed;
    logic [ADDR_W-1:0] addr;
    logic [2*ADDR_W-1:0]   lp;
    logic [2*COL_BITS-1:0] cp;

    ecc_ctrl_fsm #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .restart(restart_wr), .byte_valid(byte_valid),
        .clr(clr), .acc_en(acc_en), .done(block_done), .armed(armed),
        .addr(addr), .count(byte_count)
    );

    ecc_line_parity #(.ADDR_W(ADDR_W)) u_line (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(acc_en),
        .addr(addr), .par_bit(^byte_data), .lp(lp)
    );

    ecc_col_parity #(.DATA_W(DATA_W)) u_col (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(acc_en),
        .data(byte_data), .cp(cp)
    );

    assign ecc_result = {cp, lp};

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done && !restart_wr) |=> $stable(ecc_result) && $stable(byte_count));
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> ecc_result == '0);
    assert_restart_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_wr && byte_valid) |=> ecc_result == '0);
    assert_idle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !restart_wr) |=> $stable(ecc_result) && $stable(byte_count));
endmodule

// File: tb/ecc_block_gen_test.sv
module ecc_block_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart_wr = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [23:0] ecc_result;
    logic        block_done;
    logic [9:0]  byte_count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] blk [512];

    always #5 clk = ~clk;

    ecc_block_gen uut (
        .clk(clk), .rst_n(rst_n), .restart_wr(restart_wr), .byte_valid(byte_valid),
        .byte_data(byte_data), .ecc_result(ecc_result), .block_done(block_done),
        .byte_count(byte_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int pid, input int a);
        case (pid)
            0: return 8'h00;
            1: return 8'hFF;
            2: return (a == 0)   ? 8'h01 : 8'h00;
            3: return (a == 511) ? 8'h80 : 8'h00;
            4: return (a == 256) ? 8'h10 : 8'h00;
            5: return (a == 255) ? 8'h04 : 8'h00;
            6: return 8'(a);
            7: return 8'((a * 37 + (a >> 3)) ^ 8'hA5);
            default: return a[0] ? 8'hAA : 8'h57;
        endcase
    endfunction

    function automatic logic [23:0] model_ecc();
        logic [23:0] e = '0;
        logic [7:0]  x = '0;
        for (int a = 0; a < 512; a++) begin
            logic p = ^blk[a];
            x ^= blk[a];
            for (int n = 0; n < 9; n++) begin
                if ((a >> n) & 1) e[2*n+1] ^= p;
                else              e[2*n]   ^= p;
            end
        end
        for (int j = 0; j < 3; j++)
            for (int i = 0; i < 8; i++) begin
                if ((i >> j) & 1) e[19+2*j] ^= x[i];
                else              e[18+2*j] ^= x[i];
            end
        return e;
    endfunction

    task automatic do_restart();
        @(negedge clk); restart_wr = 1'b1;
        @(negedge clk); restart_wr = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    // feed bytes [from, to) of blk with an idle gap every 7th byte
    task automatic feed(input int from, input int to);
        for (int a = from; a < to; a++) begin
            @(negedge clk); byte_valid = 1'b1; byte_data = blk[a];
            if (a % 7 == 6) begin
                @(negedge clk); byte_valid = 1'b0; byte_data = 8'h3C;
            end
        end
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic run_block(input int pid);
        logic [23:0] held;
        for (int a = 0; a < 512; a++) blk[a] = gen_byte(pid, a);
        do_restart();
        chk("R2 clear", {8'h0, ecc_result}, 32'h0);
        feed(0, 100);
        chk("R3 count", {22'h0, byte_count}, 32'd100);
        chk("R6 not done early", {31'h0, block_done}, 32'h0);
        feed(100, 512);
        chk("R6 done", {31'h0, block_done}, 32'h1);
        chk("R6 count", {22'h0, byte_count}, 32'd512);
        chk("R4/R5 ecc", {8'h0, ecc_result}, {8'h0, model_ecc()});
        held = ecc_result;
        put_byte(8'hFF); put_byte(8'h01); put_byte(8'h7E);
        chk("R7 frozen ecc", {8'h0, ecc_result}, {8'h0, held});
        chk("R7 count cap", {22'h0, byte_count}, 32'd512);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", {31'h0, block_done}, 32'h0);
        chk("R1 count", {22'h0, byte_count}, 32'h0);
        chk("R1 ecc", {8'h0, ecc_result}, 32'h0);
        put_byte(8'h01); put_byte(8'hF3); put_byte(8'h80);
        chk("R1 idle count", {22'h0, byte_count}, 32'h0);
        chk("R1 idle ecc", {8'h0, ecc_result}, 32'h0);

        for (int pid = 0; pid < 9; pid++) run_block(pid);
        chk("R2 done held before restart", {31'h0, block_done}, 32'h1);
        do_restart();
        chk("R2 done cleared", {31'h0, block_done}, 32'h0);
        chk("R2 count cleared", {22'h0, byte_count}, 32'h0);

        // R9: abandon partial block, then a full fresh block
        for (int a = 0; a < 512; a++) blk[a] = gen_byte(7, a);
        feed(0, 200);
        chk("R9 partial count", {22'h0, byte_count}, 32'd200);
        for (int a = 0; a < 512; a++) blk[a] = gen_byte(6, a) ^ 8'h0F;
        do_restart();
        feed(0, 512);
        chk("R9 fresh ecc", {8'h0, ecc_result}, {8'h0, model_ecc()});

        // R8: restart and valid together; that byte is dropped
        for (int a = 0; a < 512; a++) blk[a] = gen_byte(3, a);
        @(negedge clk); restart_wr = 1'b1; byte_valid = 1'b1; byte_data = 8'hFE;
        @(negedge clk); restart_wr = 1'b0; byte_valid = 1'b0;
        chk("R8 count", {22'h0, byte_count}, 32'h0);
        chk("R8 ecc", {8'h0, ecc_result}, 32'h0);
        feed(0, 512);
        chk("R8 ecc after block", {8'h0, ecc_result}, {8'h0, model_ecc()});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule